// File: doc/BRIEF.md
# Bus Ownership Arbiter

This block decides which of four bus masters may drive a shared system bus that normally belongs to a processing core. Each master raises a request line. The masters are a DRAM refresh engine, an external bus master and two DMA channels. While any request is up, the arbiter asks the core to release the bus through a hold line. It waits until the core answers on its acknowledge line.

Priority is settled only when the acknowledge arrives. All requests that are active in that cycle take part, so the winner need not be the request that started the handshake. The winner keeps its grant until it lowers its own request. A higher-priority request that arrives in the meantime does not take the bus away. On release, the next pending request is served at once and the hold line stays up. When nobody is waiting, the hold line drops. No new handshake starts until the core has lowered its acknowledge.

Top module: `bus_owner_arb`

## Requirements
- R1: After reset, `hold_req` is 0 and every bit of `gnt` is 0.
- R2: From the idle state, any set bit of `req` drives `hold_req` high on the next clock edge. `hold_req` then stays high while a handshake or an ownership is in progress.
- R3: No grant is seen while `hold_ack` is low, and no grant is seen while `hold_req` is low.
- R4: The bit positions of `req` and `gnt` are: bit 0 refresh, bit 1 external master, bit 2 DMA channel 0, bit 3 DMA channel 1. Lower index has higher priority. Take the first edge at which `hold_ack` is sampled high during a handshake. At that edge the lowest set bit of `req` is granted, and the grant is visible after that edge.
- R5: At most one bit of `gnt` is set at any time.
- R6: A grant is never preempted. It stays on the same bit as long as that bit of `req` stays high, whatever other requests arrive.
- R7: When the owner lowers its request and other requests remain, the lowest remaining set bit is granted on the next edge. `hold_req` stays high.
- R8: When the owner lowers its request and no other request is set, `gnt` and `hold_req` go to 0 on the next edge.
- R9: After a release, `hold_req` stays low until `hold_ack` has been sampled low. Only then does a set request raise `hold_req` again, one edge later.
- R10: If every request is withdrawn before `hold_ack` is sampled high, no grant is given. `hold_req` falls at the edge where `hold_ack` is first sampled high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | N_SRC | Request lines, bit 0 has the highest priority |
| gnt | output | N_SRC | Grant lines, at most one set |
| hold_req | output | 1 | Request to the core to release the bus |
| hold_ack | input | 1 | Core reports that the bus is released |

## Verification
A wrong internal state shows up at the ports within one clock. A missing handshake leaves `hold_req` low one edge after a request. A stale owner either keeps a grant after its request falls or drops the grant of a still-active owner. A wrong priority pick grants the wrong bit on the edge after `hold_ack` rises. A skipped release wait raises `hold_req` while `hold_ack` is still high. The bench compares `hold_req` and `gnt` against an independent reference model in every cycle. It also runs directed sequences that check each of these edges by hand.

// File: rtl/bus_owner_arb.sv
module bus_owner_arb #(
  parameter int N_SRC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] req,
  output logic [N_SRC-1:0] gnt,
  output logic             hold_req,
  input  logic             hold_ack
);

  typedef enum logic [1:0] {IDLE, WAIT_ACK, OWN, RELEASE} st_t;

  st_t              st;
  logic [N_SRC-1:0] gnt_q;
  logic [N_SRC-1:0] pick;
  logic             any_req;
  logic             owner_live;

  always_comb begin
    pick = '0;
    for (int i = N_SRC - 1; i >= 0; i--)
      if (req[i]) pick = N_SRC'(1) << i;
  end

  assign any_req    = |req;
  assign owner_live = |(gnt_q & req);
  assign gnt        = gnt_q & {N_SRC{hold_ack}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= IDLE;
      gnt_q    <= '0;
      hold_req <= 1'b0;
    end else begin
      case (st)
        IDLE:
          if (any_req) begin
            st       <= WAIT_ACK;
            hold_req <= 1'b1;
          end
        WAIT_ACK:
          if (hold_ack) begin
            if (any_req) begin
              st    <= OWN;
              gnt_q <= pick;
            end else begin
              st       <= RELEASE;
              hold_req <= 1'b0;
            end
          end
        OWN:
          if (!owner_live) begin
            if (any_req) begin
              gnt_q <= pick;
            end else begin
              st       <= RELEASE;
              gnt_q    <= '0;
              hold_req <= 1'b0;
            end
          end
        default:
          if (!hold_ack) st <= IDLE;
      endcase
    end
  end

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt)); // R5

  AST_GNT_NEEDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (|gnt) |-> hold_req); // R3

  AST_IDLE_RAISES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st == IDLE && any_req) |=> hold_req); // R2

  AST_NO_PREEMPT: assert property (@(posedge clk) disable iff (!rst_n)
    owner_live |=> (gnt_q == $past(gnt_q))); // R6

  AST_HANDOFF_KEEPS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st == OWN && !owner_live && any_req) |=> hold_req && (gnt_q != '0)); // R7

  AST_RELEASE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == RELEASE && hold_ack) |=> !hold_req); // R9

endmodule

// File: tb/bus_owner_arb_test.sv
module bus_owner_arb_test;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] req = '0;
  logic         hold_ack = 1'b0;
  logic [N-1:0] gnt;
  logic         hold_req;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  bus_owner_arb #(.N_SRC(N)) uut (
    .clk(clk), .rst_n(rst_n), .req(req), .gnt(gnt),
    .hold_req(hold_req), .hold_ack(hold_ack)
  );

  always #2.5 clk = ~clk;

  // reference model
  int           m_ph;   // 0 idle, 1 waiting, 2 owning, 3 draining
  logic [N-1:0] m_gnt;
  logic         m_hold;

  function automatic logic [N-1:0] top_pri(input logic [N-1:0] r);
    for (int i = 0; i < N; i++)
      if (r[i]) return N'(1) << i;
    return '0;
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      m_ph <= 0; m_gnt <= '0; m_hold <= 1'b0;
    end else if (m_ph == 0) begin
      if (req != 0) begin m_ph <= 1; m_hold <= 1'b1; end
    end else if (m_ph == 1) begin
      if (hold_ack && req != 0) begin m_ph <= 2; m_gnt <= top_pri(req); end
      else if (hold_ack) begin m_ph <= 3; m_hold <= 1'b0; end
    end else if (m_ph == 2) begin
      if ((m_gnt & req) == 0) begin
        if (req != 0) m_gnt <= top_pri(req);
        else begin m_ph <= 3; m_gnt <= '0; m_hold <= 1'b0; end
      end
    end else if (!hold_ack) m_ph <= 0;
  end

  task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    if (rst_n) begin
      check("R2 hold vs model", N'(hold_req), N'(m_hold));
      check("R4 grant vs model", gnt, m_gnt & {N{hold_ack}});
      check("R5 one-hot grant", N'($countones(gnt) <= 1), N'(1));
      check("R3 grant needs ack and hold", N'(gnt != 0 && !(hold_ack && hold_req)), N'(0));
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) step();
    rst_n = 1'b1;
    check("R1 reset hold", N'(hold_req), '0);
    check("R1 reset grant", gnt, '0);

    // all four at once: priority order and handoff
    req = 4'b1111; step();
    check("R2 hold raised", N'(hold_req), N'(1));
    check("R3 no grant before ack", gnt, '0);
    hold_ack = 1'b1; step();
    check("R4 refresh wins", gnt, 4'b0001);
    req = 4'b1110; step();
    check("R7 external next", gnt, 4'b0010);
    check("R7 hold kept", N'(hold_req), N'(1));
    req = 4'b1100; step();
    check("R7 dma0 next", gnt, 4'b0100);
    req = 4'b1000; step();
    check("R7 dma1 next", gnt, 4'b1000);
    req = 4'b0000; step();
    check("R8 grant cleared", gnt, '0);
    check("R8 hold cleared", N'(hold_req), '0);
    req = 4'b0001; step(); step();
    check("R9 hold waits for ack low", N'(hold_req), '0);
    hold_ack = 1'b0; step();
    check("R9 still low on ack-low edge", N'(hold_req), '0);
    step();
    check("R9 hold after ack low", N'(hold_req), N'(1));

    // pick happens at ack time; no preemption
    req = 4'b1000; hold_ack = 1'b1; step();
    check("R4 only active at ack", gnt, 4'b1000);
    req = 4'b1001; step(); step();
    check("R6 no preemption", gnt, 4'b1000);
    req = 4'b0001; step();
    check("R7 refresh after dma1", gnt, 4'b0001);
    req = 4'b0000; step();
    check("R8 drained", N'(hold_req), '0);
    hold_ack = 1'b0; step();

    // withdraw before ack
    req = 4'b0100; step();
    check("R2 hold on dma0", N'(hold_req), N'(1));
    req = 4'b0000; step();
    check("R10 hold stays before ack", N'(hold_req), N'(1));
    hold_ack = 1'b1; step();
    check("R10 no grant", gnt, '0);
    check("R10 hold dropped", N'(hold_req), '0);
    hold_ack = 1'b0; step();

    // constrained random traffic
    for (int k = 0; k < 4000; k++) begin
      if (hold_req && !hold_ack && $urandom % 3 == 0) hold_ack = 1'b1;
      else if (!hold_req && hold_ack && $urandom % 3 == 0) hold_ack = 1'b0;
      for (int i = 0; i < N; i++) begin
        if (!req[i] && $urandom % 10 == 0) req[i] = 1'b1;
        else if (req[i] && gnt[i] && $urandom % 4 == 0) req[i] = 1'b0;
        else if (req[i] && !gnt[i] && !hold_ack && $urandom % 60 == 0) req[i] = 1'b0;
      end
      step();
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule